// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Mode

This block keeps wall-clock time and date as packed BCD bytes and advances them once per qualified pulse on a one-pulse-per-second tick input. Seconds roll into minutes, minutes into hours, hours into the day, and the day into month and year. The day of the month wraps according to the month's length and leap years for a 2000–2099 century. A day-of-week counter steps alongside the day of the month.

The hour byte chooses its own format. With bit 6 clear it counts 00–23 in BCD. With bit 6 set it counts 12-hour style: bit 5 marks the afternoon and bits 4:0 hold 01–12 in BCD. Every byte can be loaded through a simple write port. A control byte holds an active-low run bit: while its bit 7 is 1 the counter ignores ticks.

Top module: `rtcc_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00 (24-hour format), weekday 01, day 01, month 01, year 00. The run gate reads halted (`osc_halt_o` = 1).
- R2: A write with `wr_en_i` high loads `wr_data_i` into the byte selected by `wr_addr_i`. The address map is 0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day, 5 month, 6 year, 7 control. The new value appears on the outputs one clock after the write edge. Writes work whether or not the counter is halted.
- R3: Control bit 7 (only this bit is kept) is the active-low run gate, visible on `osc_halt_o`. While it is 1, ticks have no effect on any field.
- R4: Seconds and minutes count BCD 00–59. Each passes a carry to the next field when it wraps from 59 to 00.
- R5: With hour bit 6 clear, the hour counts BCD 00–23 and advances the day when it wraps from 23 to 00.
- R6: With hour bit 6 set, bits 4:0 count BCD 01–12 and bit 5 is the PM flag. 11 goes to 12 with bit 5 inverted, and 12 goes to 01 with bit 5 unchanged. The day advances only on 11 PM to 12 AM. Bit 6 never changes except by a write.
- R7: The weekday counts 01–07, advances whenever the day of the month advances, and wraps from 07 to 01.
- R8: The day of the month wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and after 28 in February of a common year. Each such wrap advances the month, and month 12 wraps to 01 and advances the year.
- R9: February has 29 days when the year's BCD value is divisible by 4, year 00 included.
- R10: The year counts BCD 00–99 and wraps from 99 to 00.
- R11: When a write and an effective tick share a clock edge, the written byte takes the written value and the tick is not applied to it. No field above it receives a carry from it. Fields below it still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Byte select for a write |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte with format and PM bits |
| wday_o | output | 8 | Weekday 01–07 |
| mday_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month 01–12, BCD |
| year_o | output | 8 | Year 00–99, BCD |
| osc_halt_o | output | 1 | Run gate, 1 = halted |

## Verification
The range and carry properties assume that every written byte is a legal BCD value for its field. They also assume that the day of the month never exceeds the length of the month in effect. The bench only writes consistent dates. It loads the month and year before the day, and it sets the day of a month no higher than that month's length. Hour bytes are always written in the format that the write selects, so the format and range checks never see a mixed encoding.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  localparam int FIELD_W  = 8;
  localparam int NUM_REGS = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  typedef logic [FIELD_W-1:0] bcd_t;

  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HOUR = 2;
  localparam int IX_WDAY = 3;
  localparam int IX_MDAY = 4;
  localparam int IX_MON  = 5;
  localparam int IX_YEAR = 6;
  localparam int IX_CTRL = 7;

  localparam int HALT_BIT = 7;

  function automatic bcd_t bcd_inc(input bcd_t v);
    bcd_t r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/rtcc_bcd_field.sv
module rtcc_bcd_field
  import rtcc_pkg::*;
#(
  parameter bcd_t RST_VAL = '0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  logic inc_i,
  input  bcd_t lo_i,
  input  bcd_t hi_i,
  output bcd_t q_o,
  output logic carry_o
);
  bcd_t q_q, q_d;
  logic at_top;

  assign at_top = (q_q >= hi_i);

  always_comb begin
    q_d = q_q;
    if (ld_i)        q_d = ld_val_i;
    else if (inc_i)  q_d = at_top ? lo_i : bcd_inc(q_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_q <= RST_VAL;
    else          q_q <= q_d;
  end

  assign q_o     = q_q;
  assign carry_o = inc_i & ~ld_i & at_top;

  // R2 / R3: without load or carry-in the byte keeps its value
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!ld_i && !inc_i) |=> $stable(q_o));
  // R11: a load always wins over a tick
  p_load_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_i |=> (q_o == $past(ld_val_i)));
  // R4/R7/R8/R10: a wrap returns to the field's low bound
  p_wrap_low_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    carry_o |=> (q_o == $past(lo_i)));
  // R4: the ones digit stays a legal BCD digit
  p_bcd_digit_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!ld_i && inc_i && !at_top) |=> (q_o[3:0] <= 4'd9));
endmodule

// File: rtl/rtcc_hour_field.sv
module rtcc_hour_field
  import rtcc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  logic inc_i,
  output bcd_t q_o,
  output logic carry_o
);
  localparam int MODE_BIT = 6;
  localparam int PM_BIT   = 5;

  bcd_t q_q, q_d;
  logic mode12, pm;
  logic [3:0] ones;
  logic [4:0] h12_next;
  logic [5:0] h24_next;
  logic wrap12, wrap24;

  assign mode12 = q_q[MODE_BIT];
  assign pm     = q_q[PM_BIT];
  assign ones   = q_q[3:0];

  always_comb begin
    if (ones == 4'd9) h12_next = {1'b1, 4'd0};
    else              h12_next = {q_q[4], ones + 4'd1};
    if (ones == 4'd9) h24_next = {q_q[5:4] + 2'd1, 4'd0};
    else              h24_next = {q_q[5:4], ones + 4'd1};
  end

  assign wrap12 = mode12 && (q_q[4:0] == 5'h11) && pm;
  assign wrap24 = !mode12 && (q_q[5:0] >= 6'h23);

  always_comb begin
    q_d = q_q;
    if (ld_i) begin
      q_d = ld_val_i;
    end else if (inc_i) begin
      if (mode12) begin
        if (q_q[4:0] == 5'h11)      q_d = {2'b01, ~pm, 5'h12};
        else if (q_q[4:0] == 5'h12) q_d = {2'b01, pm, 5'h01};
        else                        q_d = {2'b01, pm, h12_next};
      end else begin
        if (wrap24) q_d = '0;
        else        q_d = {2'b00, h24_next};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_q <= '0;
    else          q_q <= q_d;
  end

  assign q_o     = q_q;
  assign carry_o = inc_i & ~ld_i & (wrap12 | wrap24);

  // R6: the format bit only changes through a write
  p_mode_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !ld_i |=> (q_o[MODE_BIT] == $past(q_o[MODE_BIT])));
  // R6: stepping out of hour 11 flips the PM flag
  p_pm_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!ld_i && inc_i && mode12 && q_q[4:0] == 5'h11) |=> (q_o[PM_BIT] != $past(pm)));
  // R6: the 12-hour digits never show zero after a step
  p_no_zero12_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!ld_i && inc_i && mode12) |=> (q_o[4:0] != 5'h00));
  // R5: a 24-hour day carry leaves midnight behind
  p_midnight_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (carry_o && !mode12) |=> (q_o == 8'h00));
endmodule

// File: rtl/rtcc_month_len.sv
module rtcc_month_len
  import rtcc_pkg::*;
(
  input  bcd_t month_i,
  input  bcd_t year_i,
  output bcd_t last_day_o
);
  logic leap;
  logic [3:0] y_ones;

  assign y_ones = year_i[3:0];

  // A two-digit value is a multiple of 4 when an even tens digit meets
  // ones 0/4/8, or an odd tens digit meets ones 2/6.
  always_comb begin
    if (year_i[4]) leap = (y_ones == 4'd2) || (y_ones == 4'd6);
    else           leap = (y_ones == 4'd0) || (y_ones == 4'd4) || (y_ones == 4'd8);
  end

  always_comb begin
    unique case (month_i)
      8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtcc_calendar.sv
module rtcc_calendar
  import rtcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  output logic [FIELD_W-1:0] sec_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] wday_o,
  output logic [FIELD_W-1:0] mday_o,
  output logic [FIELD_W-1:0] month_o,
  output logic [FIELD_W-1:0] year_o,
  output logic              osc_halt_o
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  // write decode
  logic [NUM_REGS-1:0] ld;
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_ld
    assign ld[k] = wr_en_i && (wr_addr_i == ADDR_W'(k));
  end

  // run gate
  logic halt_q, halt_d, adv;
  always_comb begin
    halt_d = halt_q;
    if (ld[IX_CTRL]) halt_d = wr_data_i[HALT_BIT];
  end
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b1;
    else        halt_q <= halt_d;
  end
  assign adv = tick_i & ~halt_q;

  // carry chain
  logic c_sec, c_min, c_hour, c_wday, c_mday, c_mon, c_year;
  bcd_t last_day;

  rtcc_bcd_field #(.RST_VAL(8'h00)) u_sec (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(ld[IX_SEC]), .ld_val_i(wr_data_i),
    .inc_i(adv), .lo_i(8'h00), .hi_i(8'h59), .q_o(sec_o), .carry_o(c_sec));

  rtcc_bcd_field #(.RST_VAL(8'h00)) u_min (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(ld[IX_MIN]), .ld_val_i(wr_data_i),
    .inc_i(c_sec), .lo_i(8'h00), .hi_i(8'h59), .q_o(min_o), .carry_o(c_min));

  rtcc_hour_field u_hour (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(ld[IX_HOUR]), .ld_val_i(wr_data_i),
    .inc_i(c_min), .q_o(hour_o), .carry_o(c_hour));

  rtcc_bcd_field #(.RST_VAL(8'h01)) u_wday (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(ld[IX_WDAY]), .ld_val_i(wr_data_i),
    .inc_i(c_hour), .lo_i(8'h01), .hi_i(8'h07), .q_o(wday_o), .carry_o(c_wday));

  rtcc_month_len u_mlen (
    .month_i(month_o), .year_i(year_o), .last_day_o(last_day));

  rtcc_bcd_field #(.RST_VAL(8'h01)) u_mday (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(ld[IX_MDAY]), .ld_val_i(wr_data_i),
    .inc_i(c_hour), .lo_i(8'h01), .hi_i(last_day), .q_o(mday_o), .carry_o(c_mday));

  rtcc_bcd_field #(.RST_VAL(8'h01)) u_mon (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(ld[IX_MON]), .ld_val_i(wr_data_i),
    .inc_i(c_mday), .lo_i(8'h01), .hi_i(8'h12), .q_o(month_o), .carry_o(c_mon));

  rtcc_bcd_field #(.RST_VAL(8'h00)) u_year (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(ld[IX_YEAR]), .ld_val_i(wr_data_i),
    .inc_i(c_mon), .lo_i(8'h00), .hi_i(8'h99), .q_o(year_o), .carry_o(c_year));

  assign osc_halt_o = halt_q;

  // R3: a halted counter with no write keeps every field
  p_halt_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (halt_q && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(mday_o) && $stable(month_o) && $stable(year_o) && $stable(wday_o)));
  // R7: weekday and day of month step on the same edge
  p_wday_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (c_hour && !wr_en_i) |=> (wday_o != $past(wday_o)) && (mday_o != $past(mday_o)));
  // R7: weekday wraps from 07 to 01
  p_wday_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    c_wday |=> (wday_o == 8'h01));
  // R10: the century wrap lands on 00
  p_century_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    c_year |=> (year_o == 8'h00));
  // R8: new month starts on day 01
  p_month_step_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    c_mday |=> (mday_o == 8'h01));
  // R11: a loaded minute byte passes no carry upward
  p_no_carry_past_load_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ld[IX_MIN] && !ld[IX_HOUR]) |=> $stable(hour_o));
endmodule

// File: tb/rtcc_calendar_bench.sv
module rtcc_calendar_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, mn, hr, wd, md, mo, yr;
  logic       halt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtcc_calendar u_rtcc_calendar (
    .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(mn), .hour_o(hr), .wday_o(wd), .mday_o(md),
    .month_o(mo), .year_o(yr), .osc_halt_o(halt));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc12(input int h24);
    int d;
    d = h24 % 12;
    if (d == 0) d = 12;
    return 8'h40 | (h24 >= 12 ? 8'h20 : 8'h00) | bcd(d);
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_tick(input int a, input logic [7:0] d);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 sec", sec, 8'h00);  check("R1 min", mn, 8'h00);
    check("R1 hour", hr, 8'h00);  check("R1 wday", wd, 8'h01);
    check("R1 mday", md, 8'h01);  check("R1 month", mo, 8'h01);
    check("R1 year", yr, 8'h00);  check("R1 halt", {7'd0, halt}, 8'h01);

    // R3 ticks ignored while halted; R2 writes still land
    for (int i = 0; i < 5; i++) tick1();
    check("R3 sec frozen", sec, 8'h00);
    wr(0, 8'h42);
    check("R2 write while halted", sec, 8'h42);
    tick1();
    check("R3 sec still frozen", sec, 8'h42);
    wr(0, 8'h00);
    wr(7, 8'h7f);
    check("R3 only bit7 gates", {7'd0, halt}, 8'h00);

    // R4 R5 full day in 24-hour format, one tick per cycle
    @(negedge clk);
    tick = 1'b1;
    for (int i = 1; i <= 86400; i++) begin
      @(negedge clk);
      if (i == 86400) tick = 1'b0;
      check("R4 sec", sec, bcd(i % 60));
      check("R4 min", mn, bcd((i / 60) % 60));
      check("R5 hour", hr, bcd((i / 3600) % 24));
    end
    check("R5 day carry", md, 8'h02);
    check("R7 wday step", wd, 8'h02);

    // R6 12-hour format across every hour boundary; R7 wday wrap
    wr(5, 8'h01); wr(6, 8'h00);
    for (int h = 0; h < 24; h++) begin
      wr(4, 8'h05); wr(3, 8'h07);
      wr(2, enc12(h)); wr(1, 8'h59); wr(0, 8'h59);
      tick1();
      check("R6 hour12", hr, enc12((h + 1) % 24));
      check("R6 min wrap", mn, 8'h00);
      check("R6 day", md, (h == 23) ? 8'h06 : 8'h05);
      check("R7 wday wrap", wd, (h == 23) ? 8'h01 : 8'h07);
    end

    // R8 R9 R10 month ends for every month of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        wr(6, bcd(y)); wr(5, bcd(m)); wr(4, bcd(days_in(m, y)));
        wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
        tick1();
        check("R8 mday wrap", md, 8'h01);
        check("R8 month step", mo, bcd(m % 12 + 1));
        check("R10 year", yr, bcd(m == 12 ? (y + 1) % 100 : y));
      end
      wr(6, bcd(y)); wr(5, 8'h02); wr(4, 8'h28);
      wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
      tick1();
      check("R9 feb 28 step", md, (y % 4 == 0) ? 8'h29 : 8'h01);
    end

    // R11 load priority against a tick
    wr(2, 8'h00); wr(1, 8'h00); wr(0, 8'h59);
    wr_tick(1, 8'h30);
    check("R11 lower field advances", sec, 8'h00);
    check("R11 loaded min", mn, 8'h30);
    check("R11 hour untouched", hr, 8'h00);
    wr(2, 8'h05); wr(1, 8'h59); wr(0, 8'h59);
    wr_tick(0, 8'h10);
    check("R11 loaded sec no step", sec, 8'h10);
    check("R11 no carry upward", mn, 8'h59);
    check("R11 hour kept", hr, 8'h05);
    wr(0, 8'h20);
    wr_tick(2, 8'h47);
    check("R11 sec steps under hour load", sec, 8'h21);
    check("R11 hour12 loaded", hr, 8'h47);

    // R3 halt again mid-run
    wr(7, 8'h80);
    check("R3 halt flag", {7'd0, halt}, 8'h01);
    for (int i = 0; i < 3; i++) tick1();
    check("R3 halted sec", sec, 8'h21);

    done = 1;
    summary();
  end
endmodule